// File: doc/BRIEF.md
# Pulse-Period Measurement Counter

This block turns the pulse train of a voltage-to-frequency converter into a binary word. The block does not count input pulses over a fixed gate. It counts cycles of a fast, stable reference clock across one full period of the pulse input, so each conversion takes one input period. The host converts the period to a frequency afterwards.

The asynchronous pulse input passes through a synchronizer. Its rising edges are detected in the reference domain. Each accepted edge closes the running measurement, captures the count into a holding register and starts a two-cycle clear window. Counting for the next period starts after that window. The held count is shown raw, with the fixed three-cycle offset of the sequence added back, and with an extra pulse-width term subtracted. A one-cycle strobe marks each new result. An overflow flag marks a period too long for the counter.

Top module: `pulse_period_meter`

## Requirements
- R1: Let P be the number of reference cycles between two accepted rising edges of `pulse_in`. The raw result `period_raw` is P-3, and `period_full` is P.
- R2: `pulse_in` is sampled through a chain of SYNC_STAGES flip-flops. Only low-to-high transitions count as edges. An accepted edge ends one measurement and begins the next.
- R3: While `rst_n` is low, and afterwards until a full period has been measured, `result_valid` is 0. Out of reset, `period_raw` is 0, `overflow` is 0 and `period_full` is 3. The first edge after reset gives no result.
- R4: `result_valid` is high for exactly one cycle per result, in the first cycle that shows the new held values. The held values do not change between strobes.
- R5: An edge that arrives one or two cycles after an accepted edge falls in the clear window and is ignored. The next edge is then measured from the last accepted edge.
- R6: The shortest measurable spacing, P = 3, gives `period_raw` = 0.
- R7: The counter saturates at 2^CNT_W-1. `overflow` is 1 with a result exactly when P-3 exceeds 2^CNT_W-1, and it is 0 again with the next result that fits.
- R8: `period_trim` equals P minus `pw_ticks` when P is larger than `pw_ticks`, and 0 otherwise.
- R9: A reset applied mid-run discards any partial period. Measurement starts again as after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Asynchronous pulse train from the converter |
| pw_ticks | input | U_W | Pulse-width correction in reference cycles |
| period_raw | output | CNT_W | Held raw count |
| period_full | output | CNT_W+2 | Held count plus 3 (true period) |
| period_trim | output | CNT_W+2 | True period minus pw_ticks, floored at 0 |
| result_valid | output | 1 | One-cycle strobe for a new result |
| overflow | output | 1 | Held result saturated |

## Verification
Two events can fall in the same cycle. An input edge can arrive in the clear window just after a capture, or in the very first counting cycle after it. The bench drives edges at spacings of 2, 3 and 4 reference cycles after an accepted edge. A scoreboard checks that a spacing of 2 yields no result and moves the next result forward, and that spacings of 3 and 4 give counts of 0 and 1. Saturation against capture is covered the same way, at one cycle below and one cycle above the overflow limit.

// File: rtl/ppm_pkg.sv
// Shared types for the pulse-period meter.
package ppm_pkg;
    // Sequencer phases: waiting for first edge, counting, two clear cycles
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_COUNT = 2'd1,
        SEQ_HOLD  = 2'd2,
        SEQ_CLEAR = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ppm_sync.sv
// Input synchronizer and rising-edge detector.
// Assumes async_in may change at any time relative to clk. The output
// rise is a single-cycle pulse per low-to-high transition of the input.
module ppm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizing flops plus one delay flop for edge detection
    logic [STAGES:0] chain_q;

    // Shift the raw input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    // Edge is seen when the synchronized level is high and was low
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R2: a detected edge never lasts two cycles
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ppm_seq.sv
// Start/stop/capture/clear sequencer with saturating period counter.
// Assumes rise is a synchronous single-cycle pulse. An edge in COUNT
// captures the count; the counter is cleared on the second clock after
// capture; edges during the two clear cycles are ignored.
module ppm_seq
    import ppm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] held,
    output logic             valid,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sat_q;

    // Sequencer, counter and capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            sat_q   <= 1'b0;
            held    <= '0;
            valid   <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (rise) state_q <= SEQ_HOLD;
                end
                SEQ_COUNT: begin
                    if (rise) begin
                        held    <= cnt_q;
                        ovf     <= sat_q;
                        valid   <= 1'b1;
                        state_q <= SEQ_HOLD;
                    end else if (cnt_q == CNT_MAX) begin
                        sat_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    state_q <= SEQ_CLEAR;
                end
                default: begin
                    cnt_q   <= '0;
                    sat_q   <= 1'b0;
                    state_q <= SEQ_COUNT;
                end
            endcase
        end
    end

    // R4: strobe lasts one cycle
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R4: held result only moves together with a strobe
    p_held_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(held));

    // R5: an edge inside the clear window produces no result
    p_gap_edge_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (state_q == SEQ_HOLD || state_q == SEQ_CLEAR)) |=> !valid);

    // R7: overflow only accompanies a saturated count
    p_ovf_saturated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (held == CNT_MAX));
endmodule

// File: rtl/ppm_correct.sv
// Offset correction of the held count.
// Adds the fixed three-cycle sequencing offset and subtracts a
// pulse-width term, flooring the trimmed result at zero.
module ppm_correct #(
    parameter int CNT_W = 24,
    parameter int U_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   held,
    input  logic [U_W-1:0]     u_ticks,
    output logic [CNT_W+1:0]   full,
    output logic [CNT_W+1:0]   trim
);
    localparam int OUT_W = CNT_W + 2;

    logic [OUT_W-1:0] u_ext;

    // Restore the true period and apply the width correction
    always_comb begin
        u_ext = OUT_W'(u_ticks);
        full  = {2'b00, held} + OUT_W'(3);
        trim  = (full > u_ext) ? (full - u_ext) : '0;
    end

    // R8: trimmed period never exceeds the full period
    p_trim_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trim <= full);
endmodule

// File: rtl/pulse_period_meter.sv
// Pulse-period measurement counter, top level.
// Assumes clk is a stable reference much faster than pulse_in.
// Produces one result per accepted input period.
module pulse_period_meter #(
    parameter int CNT_W       = 24,
    parameter int U_W         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic [U_W-1:0]   pw_ticks,
    output logic [CNT_W-1:0] period_raw,
    output logic [CNT_W+1:0] period_full,
    output logic [CNT_W+1:0] period_trim,
    output logic             result_valid,
    output logic             overflow
);
    logic edge_seen;

    ppm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise     (edge_seen)
    );

    ppm_seq #(.CNT_W(CNT_W)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (edge_seen),
        .held  (period_raw),
        .valid (result_valid),
        .ovf   (overflow)
    );

    ppm_correct #(.CNT_W(CNT_W), .U_W(U_W)) corr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .held    (period_raw),
        .u_ticks (pw_ticks),
        .full    (period_full),
        .trim    (period_trim)
    );
endmodule

// File: tb/pulse_period_meter_tb_top.sv
module pulse_period_meter_tb_top;
    localparam int CW   = 10;
    localparam int UW   = 8;
    localparam int MAXC = (1 << CW) - 1;
    localparam int PW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic [UW-1:0] pw_ticks = UW'(PW);
    logic [CW-1:0] period_raw;
    logic [CW+1:0] period_full;
    logic [CW+1:0] period_trim;
    logic          result_valid;
    logic          overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    typedef struct { int raw; int ovf; } exp_t;
    exp_t exp_q[$];

    int armed = 0;
    int since = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pulse_period_meter #(.CNT_W(CW), .U_W(UW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .pw_ticks(pw_ticks),
        .period_raw(period_raw), .period_full(period_full),
        .period_trim(period_trim), .result_valid(result_valid),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: one rising edge now, then g cycles until the next one
    task automatic edge_then(input int g);
        exp_t e;
        if (armed == 0) begin
            armed = 1; since = 0;                 // R3: first edge only arms
        end else if (since <= 2) begin
            // R5: edge in clear window ignored, keep distance from last accepted
        end else begin
            e.raw = (since - 3 > MAXC) ? MAXC : since - 3;   // R1, R6, R7
            e.ovf = (since - 3 > MAXC) ? 1 : 0;
            exp_q.push_back(e);
            since = 0;
        end
        @(negedge clk) pulse_in = 1'b1;
        @(negedge clk) pulse_in = 1'b0;
        repeat (g - 2) @(negedge clk);
        since += g;
    endtask

    // Monitor: compare each strobed result against the queue
    bit prev_valid = 1'b0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (prev_valid && result_valid)
                check(1'b0, "R4 strobe longer than one cycle", 1, 0);
            if (result_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R5 unexpected result", int'(period_raw), -1);
                end else begin
                    exp_t e;
                    int full_e, trim_e;
                    e = exp_q.pop_front();
                    full_e = e.raw + 3;
                    trim_e = (full_e > PW) ? full_e - PW : 0;
                    check(int'(period_raw) == e.raw, "R1 period_raw", int'(period_raw), e.raw);
                    check(int'(period_full) == full_e, "R1 period_full", int'(period_full), full_e);
                    check(int'(period_trim) == trim_e, "R8 period_trim", int'(period_trim), trim_e);
                    check(int'(overflow) == e.ovf, "R7 overflow", int'(overflow), e.ovf);
                end
            end
        end
        prev_valid = result_valid;
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", cycles, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        check(result_valid == 1'b0, "R3 valid after reset", int'(result_valid), 0);
        check(period_raw == '0, "R3 raw after reset", int'(period_raw), 0);
        check(overflow == 1'b0, "R3 overflow after reset", int'(overflow), 0);
        check(int'(period_full) == 3, "R3 full after reset", int'(period_full), 3);

        edge_then(50);     // arms only (R3)
        edge_then(3);      // R1: N=47
        edge_then(4);      // R6: N=0
        edge_then(2);      // N=1, then spacing 2 follows
        edge_then(37);     // R5: ignored edge
        edge_then(200);    // N=36 measured from accepted edge
        edge_then(1026);   // N=197
        edge_then(1027);   // R7: N=1023 without overflow
        edge_then(60);     // R7: saturated, overflow
        edge_then(2);      // N=57, overflow cleared
        edge_then(2);      // ignored
        edge_then(20);     // N=1 (spacing 4 from accepted)
        edge_then(20);     // N=17

        // R9: reset mid-run discards the partial period
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 0; since = 0;
        @(negedge clk);
        check(result_valid == 1'b0, "R9 valid after mid reset", int'(result_valid), 0);
        check(period_raw == '0, "R9 raw after mid reset", int'(period_raw), 0);
        edge_then(10);     // arms only
        edge_then(15);     // N=7
        edge_then(10);     // N=12
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule